// File: doc/BRIEF.md
# Self-Timed Flash Byte Programming Sequencer

This block sequences parallel-mode programming of a byte-wide code store of 4K locations, held here as an internal register array. A host presents an address, a data byte and a two-bit mode code. It then pulses an active-low program strobe. In write mode a single strobe starts a self-timed byte write. The write can only clear bits, so the stored byte becomes the old contents ANDed with the new data. The `ready` output stays low until the write has finished.

Software-visible completion is available two ways. One is the `ready` flag. The other is data polling: reading the address being written returns the final byte with bit 7 inverted until the write has finished. A whole-array erase requires the strobe to be held low in erase mode for a minimum number of cycles. A shorter strobe is discarded.

Verify reads return stored bytes only when the external lock guard grants permission. A signature mode returns three fixed identification bytes. The write time, the erase busy time and the minimum erase strobe width are parameters given in clock cycles.

Top module: `fpgm_seq`

## Requirements
- R1: After reset, `ready` is 1 and every location reads FFH.
- R2: A falling `prog_n` with `mode`=00 (write) while `ready` is 1 drops `ready` after that clock edge. `ready` then stays low for exactly WR_CYC cycles.
- R3: When a write finishes, the location holds its previous contents ANDed with `wdata`. Bits can be cleared but never set.
- R4: While a write is running, a verify read (`mode`=01) of the address being written returns the final byte with bit 7 inverted. Reads of other addresses return their stored bytes. After completion, the true byte is returned.
- R5: A strobe that falls while `ready` is 0 has no effect: no data is stored and no further busy period follows.
- R6: With `mode`=10 (erase), a strobe held low for at least ERASE_MIN clock edges sets every location to FFH when it is released. `ready` then goes low for ERS_BUSY cycles.
- R7: An erase strobe released after fewer than ERASE_MIN low edges leaves the array unchanged, and `ready` stays 1.
- R8: With `mode`=11 (signature), addresses 030H, 031H and 032H read 1EH, 51H and FFH (FFH when HIGH_VOLT=1, 05H otherwise). Any other address reads 00H.
- R9: A verify read while `verify_ok` is 0 returns FFH regardless of the stored byte.
- R10: `rdata` is registered. It reflects the `mode`/`addr` of the previous clock edge, and it is 00H in write and erase modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 00 write, 01 verify, 10 erase, 11 signature |
| addr | input | ADDR_W | Location address |
| wdata | input | 8 | Byte to program |
| prog_n | input | 1 | Active-low program strobe, synchronous to clk |
| verify_ok | input | 1 | Verify permission from the lock guard |
| rdata | output | 8 | Registered read data |
| ready | output | 1 | 1 when idle, 0 while a write or erase is timing |

## Verification
Each read result appears on `rdata` one clock edge after the address and mode are applied. The scoreboard therefore samples each queued read 1 ns after the next rising edge.

`ready` falls at the first edge that sees the strobe low. For an erase, it falls at the edge that sees the release. The bench counts low cycles at falling edges over a fixed window and compares the count with WR_CYC, ERS_BUSY or zero.

A written byte becomes readable one edge after `ready` returns high. Polling reads are placed two edges after the strobe, well inside the busy window.

// File: rtl/fpgm_pkg.sv
// Shared mode codes and constants for the programming sequencer.
package fpgm_pkg;
    typedef enum logic [1:0] {
        MD_WRITE  = 2'b00,
        MD_VERIFY = 2'b01,
        MD_ERASE  = 2'b10,
        MD_SIGN   = 2'b11
    } pgm_mode_e;

    localparam logic [7:0] BLANK_BYTE = 8'hFF;
    localparam logic [7:0] SIG_MAKER  = 8'h1E;
    localparam logic [7:0] SIG_DEVICE = 8'h51;
    localparam logic [7:0] SIG_HV     = 8'hFF;
    localparam logic [7:0] SIG_LV     = 8'h05;
endpackage

// File: rtl/fpgm_pulse.sv
// Strobe edge detector and erase-width qualifier.
// Assumes prog_n is already synchronous to clk. The hold counter saturates
// at MIN_W, so long_ok marks a held strobe that has met the minimum width.
module fpgm_pulse #(
    parameter int MIN_W = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_n,
    input  logic arm,
    output logic fall,
    output logic rise,
    output logic long_ok
);
    localparam int CW = $clog2(MIN_W + 1);

    logic          prog_q;
    logic          holding;
    logic [CW-1:0] hcnt;

    assign fall    = prog_q & ~prog_n;
    assign rise    = ~prog_q & prog_n;
    assign long_ok = holding && (hcnt >= CW'(MIN_W));

    // Previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prog_q <= 1'b1;
        else        prog_q <= prog_n;
    end

    // Count the clock edges during which an armed erase strobe stays low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holding <= 1'b0;
            hcnt    <= '0;
        end else if (arm) begin
            holding <= 1'b1;
            hcnt    <= CW'(1);
        end else if (holding) begin
            if (rise)                   holding <= 1'b0;
            else if (hcnt < CW'(MIN_W)) hcnt    <= hcnt + CW'(1);
        end
    end
endmodule

// File: rtl/fpgm_timer.sv
// Busy timer for byte writes and erases.
// A start loads the duration for its kind and drops ready. done pulses in
// the last busy cycle, and ready rises at the following edge.
module fpgm_timer #(
    parameter int WR_CYC = 187500,
    parameter int ER_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic start_er,
    output logic ready,
    output logic kind_wr,
    output logic done
);
    localparam int MAXC = (WR_CYC > ER_CYC) ? WR_CYC : ER_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    assign done = !ready && (cnt == '0);

    // Load, count down and release the busy period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready   <= 1'b1;
            kind_wr <= 1'b0;
            cnt     <= '0;
        end else if (start_wr) begin
            ready   <= 1'b0;
            kind_wr <= 1'b1;
            cnt     <= CW'(WR_CYC - 1);
        end else if (start_er) begin
            ready   <= 1'b0;
            kind_wr <= 1'b0;
            cnt     <= CW'(ER_CYC - 1);
        end else if (!ready) begin
            if (cnt == '0) ready <= 1'b1;
            else           cnt   <= cnt - CW'(1);
        end
    end
endmodule

// File: rtl/fpgm_array.sv
// Code store with a pending-write holding register.
// At the start of a write it captures the target address and the ANDed
// result. The array itself is updated only on commit. An erase sets every
// location to blank in one edge.
module fpgm_array #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              commit,
    input  logic              erase,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [7:0]        pend_byte
);
    import fpgm_pkg::*;
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    assign rd_byte = mem[rd_addr];

    // Capture the target and the bit-clearing result when a write starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_byte <= BLANK_BYTE;
        end else if (start_wr) begin
            pend_addr <= wr_addr;
            pend_byte <= mem[wr_addr] & wr_data;
        end
    end

    // Array update: blank on reset or erase, pending byte on commit.
    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK_BYTE;
        end else if (commit) begin
            mem[pend_addr] <= pend_byte;
        end
    end
endmodule

// File: rtl/fpgm_rdmux.sv
// Registered read-data selector: verify with lock gating and data polling,
// fixed signature bytes, and zero in the programming modes.
module fpgm_rdmux #(
    parameter int ADDR_W    = 12,
    parameter bit HIGH_VOLT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              verify_ok,
    input  logic              poll_hit,
    input  logic [7:0]        stored,
    input  logic [7:0]        pend_byte,
    output logic [7:0]        rdata
);
    import fpgm_pkg::*;
    localparam logic [ADDR_W-1:0] SIG_A0 = ADDR_W'(48);
    localparam logic [ADDR_W-1:0] SIG_A1 = ADDR_W'(49);
    localparam logic [ADDR_W-1:0] SIG_A2 = ADDR_W'(50);
    localparam logic [7:0] SIG_VOLT = HIGH_VOLT ? SIG_HV : SIG_LV;

    pgm_mode_e  md;
    logic [7:0] nxt;

    assign md = pgm_mode_e'(mode);

    // Select the byte to present at the next edge.
    always_comb begin
        nxt = 8'h00;
        case (md)
            MD_VERIFY: begin
                if (!verify_ok)    nxt = BLANK_BYTE;
                else if (poll_hit) nxt = {~pend_byte[7], pend_byte[6:0]};
                else               nxt = stored;
            end
            MD_SIGN: begin
                if (addr == SIG_A0)      nxt = SIG_MAKER;
                else if (addr == SIG_A1) nxt = SIG_DEVICE;
                else if (addr == SIG_A2) nxt = SIG_VOLT;
            end
            default: nxt = 8'h00;
        endcase
    end

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= 8'h00;
        else        rdata <= nxt;
    end
endmodule

// File: rtl/fpgm_seq.sv
// Top of the programming sequencer. It decodes strobe edges against the
// mode code and accepts work only while ready. It also starts timed writes
// and erases and joins the store to the read path.
// Assumes every input is synchronous to clk.
module fpgm_seq #(
    parameter int ADDR_W    = 12,
    parameter int WR_CYC    = 187500,
    parameter int ERS_BUSY  = 1250,
    parameter int ERASE_MIN = 1250000,
    parameter bit HIGH_VOLT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              prog_n,
    input  logic              verify_ok,
    output logic [7:0]        rdata,
    output logic              ready
);
    import fpgm_pkg::*;

    logic              fall, rise, long_ok;
    logic              start_wr, arm_er, erase_go;
    logic              kind_wr, done, commit, poll_hit;
    logic [7:0]        stored, pend_byte;
    logic [ADDR_W-1:0] pend_addr;

    assign start_wr = fall && ready && (pgm_mode_e'(mode) == MD_WRITE);
    assign arm_er   = fall && ready && (pgm_mode_e'(mode) == MD_ERASE);
    assign erase_go = rise && long_ok;
    assign commit   = done && kind_wr;
    assign poll_hit = !ready && kind_wr && (addr == pend_addr);

    fpgm_pulse #(.MIN_W(ERASE_MIN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .arm(arm_er),
        .fall(fall), .rise(rise), .long_ok(long_ok)
    );

    fpgm_timer #(.WR_CYC(WR_CYC), .ER_CYC(ERS_BUSY)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_er(erase_go),
        .ready(ready), .kind_wr(kind_wr), .done(done)
    );

    fpgm_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .wr_addr(addr),
        .wr_data(wdata), .commit(commit), .erase(erase_go), .rd_addr(addr),
        .rd_byte(stored), .pend_addr(pend_addr), .pend_byte(pend_byte)
    );

    fpgm_rdmux #(.ADDR_W(ADDR_W), .HIGH_VOLT(HIGH_VOLT)) u_rdmux (
        .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr),
        .verify_ok(verify_ok), .poll_hit(poll_hit), .stored(stored),
        .pend_byte(pend_byte), .rdata(rdata)
    );
endmodule

// File: rtl/fpgm_seq_chk.sv
// Temporal checks on the sequencer, bound into every instance of the top.
module fpgm_seq_chk #(
    parameter int ADDR_W   = 12,
    parameter int WR_CYC   = 187500,
    parameter int ERS_BUSY = 1250
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic [ADDR_W-1:0] addr,
    input logic              prog_n,
    input logic              verify_ok,
    input logic [7:0]        rdata,
    input logic              ready,
    input logic              erase_go,
    input logic [ADDR_W-1:0] pend_addr
);
    logic [31:0] lowcnt;

    // Length of the current low stretch of ready.
    always_ff @(posedge clk) begin
        if (!rst_n)      lowcnt <= '0;
        else if (!ready) lowcnt <= lowcnt + 32'd1;
        else             lowcnt <= '0;
    end

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $fell(prog_n) && mode == 2'b00) |=> !ready);

    a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (lowcnt == 32'(WR_CYC) || lowcnt == 32'(ERS_BUSY)));

    a_r5_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $fell(prog_n)) |=> $stable(pend_addr));

    a_r6_erase_busy: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> !ready);

    a_r7_short_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(prog_n) && ready && !erase_go) |=> ready);

    a_r8_sig_maker: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && addr == ADDR_W'(48)) |=> rdata == 8'h1E);

    a_r9_lock_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !verify_ok) |=> rdata == 8'hFF);

    a_r10_prog_modes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 || mode == 2'b10) |=> rdata == 8'h00);
endmodule

bind fpgm_seq fpgm_seq_chk #(.ADDR_W(ADDR_W), .WR_CYC(WR_CYC), .ERS_BUSY(ERS_BUSY)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .prog_n(prog_n),
    .verify_ok(verify_ok), .rdata(rdata), .ready(ready),
    .erase_go(erase_go), .pend_addr(pend_addr)
);

// File: tb/fpgm_seq_tb.sv
module fpgm_seq_tb;
    localparam int AW = 12;
    localparam int WR = 24;
    localparam int EB = 8;
    localparam int EM = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'b01;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = 8'h00;
    logic          prog_n = 1'b1;
    logic          verify_ok = 1'b1;
    logic [7:0]    rdata;
    logic          ready;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    ended = 1'b0;
    string tq[$];
    logic [7:0] eq[$];

    fpgm_seq #(.ADDR_W(AW), .WR_CYC(WR), .ERS_BUSY(EB), .ERASE_MIN(EM), .HIGH_VOLT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .wdata(wdata),
        .prog_n(prog_n), .verify_ok(verify_ok), .rdata(rdata), .ready(ready)
    );

    always #4 clk = ~clk;

    task automatic chk_int(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: present a read and queue its expected byte.
    task automatic rd(input logic [1:0] m, input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        mode = m;
        addr = a;
        tq.push_back(tag);
        eq.push_back(exp);
    endtask

    // Monitor: the queued read is due one edge after it was driven.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (eq.size() > 0) begin
                string      t;
                logic [7:0] e;
                t = tq.pop_front();
                e = eq.pop_front();
                n_chk++;
                if (rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic pulse(input logic [1:0] m, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        mode = m; addr = a; wdata = d; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1;
    endtask

    task automatic erase_pulse(input int len);
        @(negedge clk);
        mode = 2'b10; prog_n = 1'b0;
        repeat (len) @(negedge clk);
        prog_n = 1'b1;
    endtask

    task automatic count_low(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (!ready) c++;
            @(negedge clk);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
        int c;
        pulse(2'b00, a, d);
        count_low(WR + 4, c);
        chk_int("R2 write busy length", c, WR);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int c;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_int("R1 ready after reset", int'(ready), 1);
        rd(2'b01, 12'h000, 8'hFF, "R1 blank low");
        rd(2'b01, 12'hFFF, 8'hFF, "R1 blank high");
        rd(2'b00, 12'h000, 8'h00, "R10 write mode reads zero");

        // R3: writes only clear bits
        do_write(12'h010, 8'hF0);
        rd(2'b01, 12'h010, 8'hF0, "R3 first write");
        do_write(12'h010, 8'h0F);
        rd(2'b01, 12'h010, 8'h00, "R3 and of two writes");
        do_write(12'h011, 8'h3C);
        do_write(12'h011, 8'hFF);
        rd(2'b01, 12'h011, 8'h3C, "R3 cannot set bits");

        // R4: data polling during a write
        pulse(2'b00, 12'h100, 8'h5A);
        rd(2'b01, 12'h100, 8'hDA, "R4 poll inverts bit7");
        rd(2'b01, 12'h101, 8'hFF, "R4 other address");
        count_low(WR + 4, c);
        rd(2'b01, 12'h100, 8'h5A, "R4 true data after done");

        // R5: strobe while busy is ignored
        pulse(2'b00, 12'h200, 8'h0F);
        repeat (2) @(negedge clk);
        pulse(2'b00, 12'h201, 8'h00);
        count_low(WR + 4, c);
        count_low(4, c);
        chk_int("R5 no second busy", c, 0);
        rd(2'b01, 12'h201, 8'hFF, "R5 busy write not stored");
        rd(2'b01, 12'h200, 8'h0F, "R5 first write intact");

        // R8: signature bytes
        rd(2'b11, 12'h030, 8'h1E, "R8 maker");
        rd(2'b11, 12'h031, 8'h51, "R8 device");
        rd(2'b11, 12'h032, 8'hFF, "R8 voltage");
        rd(2'b11, 12'h033, 8'h00, "R8 other");

        // R9: lock gating
        @(negedge clk);
        verify_ok = 1'b0;
        rd(2'b01, 12'h010, 8'hFF, "R9 locked verify");
        @(negedge clk);
        verify_ok = 1'b1;
        rd(2'b01, 12'h010, 8'h00, "R9 unlocked verify");

        // R7: short erase strobe
        erase_pulse(EM - 1);
        count_low(EB + 4, c);
        chk_int("R7 short erase no busy", c, 0);
        rd(2'b01, 12'h010, 8'h00, "R7 array unchanged");

        // R6: full erase
        erase_pulse(EM);
        count_low(EB + 4, c);
        chk_int("R6 erase busy length", c, EB);
        rd(2'b01, 12'h010, 8'hFF, "R6 erased 010");
        rd(2'b01, 12'h011, 8'hFF, "R6 erased 011");
        rd(2'b01, 12'h200, 8'hFF, "R6 erased 200");
        rd(2'b10, 12'h200, 8'h00, "R10 erase mode reads zero");
        do_write(12'h010, 8'hA5);
        rd(2'b01, 12'h010, 8'hA5, "R6 write after erase");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule